// File: doc/BRIEF.md
# Peripheral Interrupt Router

This block gathers the interrupt lines of up to 24 peripherals and steers each one onto one of nine general-purpose priority request lines. The lines serve core levels 7 through 15 and go to the core's event controller. Every source has a 4-bit routing field held in three 32-bit assignment words. Software can therefore move any peripheral to any of the nine levels, and several peripherals may share one level. A live status word tells software which of the sharing sources is actually raising its line.

A per-source mask decides which sources may reach a level line. A separate per-source wake enable decides which sources raise the wake output while the core reports itself idle. The mask has no effect on wake. All six registers sit behind a plain single-cycle read/write port. The port carries control and status only, so it has no valid/ready handshake. A write takes effect at the next clock edge, and a read returns combinationally in the same cycle.

Top module: `pirq_router`

## Requirements
- R1: After reset, the mask word and the wake-enable word read 0, and `lvl_req` and `wake` are low. The assignment words at addresses 3, 4 and 5 read 0x10000000, 0x33322221 and 0x66655444. Those values route sources 0–6 to level 7, 7–8 to level 8, 9–12 to level 9, 13–15 to level 10, 16–18 to level 11, 19–20 to level 12 and 21–23 to level 13.
- R2: The word address selects the register: 0 is the mask, 1 is the status, 2 is the wake enable, and 3, 4 and 5 are the assignment words. Bit i of the mask, status and wake-enable words belongs to source i. Bits 31:24 of those three words read 0, and writes to those bits are dropped.
- R3: The status word reads the raw `src_irq` in the same cycle, whatever the mask holds. A write to address 1 changes nothing.
- R4: When source i is high and mask bit i is 1, `lvl_req[k]` is high in the next cycle, where k is the value in source i's routing field. Bit k of `lvl_req` stands for core level 7+k.
- R5: A source whose mask bit is 0 never raises any `lvl_req` bit.
- R6: Source i's routing field sits in the word at address 3+i/8, at bits 4*(i%8)+3 down to 4*(i%8). The field holds the target level minus 7. Rewriting the field moves the source's requests to the new level from the cycle after the write.
- R7: A routing field holding 9 to 15 sends its source to no level. All 4 bits of every field read back exactly as written.
- R8: `wake` is high in the cycle after a cycle in which `core_idle` was high and at least one source was high with its wake-enable bit set. Otherwise `wake` is low, and the mask has no effect on it.
- R9: A level line is the OR of every unmasked, asserted source routed to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 24 | Peripheral interrupt lines, bit i for source i |
| core_idle | input | 1 | High while the core is idle |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| lvl_req | output | 9 | Request lines, bit k for core level 7+k |
| wake | output | 1 | Wake request for an idle core |

## Verification
`lvl_req` and `wake` are registered, so each one reflects the inputs and configuration from exactly one clock edge earlier. Register reads are combinational and settle within the same cycle. The driver stamps each expected output pair with the cycle number at which it falls due, which is one edge after the stimulus. The monitor pops an entry at the falling edge of that cycle and compares it. Reads are compared shortly after the address is driven, and every register write completes at its edge before the stimulus that depends on it is applied.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int REG_W   = 32;
  localparam int FIELD_W = 4;

  typedef enum logic [2:0] {
    A_MASK = 3'd0,
    A_STAT = 3'd1,
    A_WAKE = 3'd2,
    A_ASG0 = 3'd3
  } addr_e;

  // routing field value at reset for a given source index
  function automatic logic [FIELD_W-1:0] dflt_field(input int idx);
    if (idx < 7)       return 4'd0;
    else if (idx < 9)  return 4'd1;
    else if (idx < 13) return 4'd2;
    else if (idx < 16) return 4'd3;
    else if (idx < 19) return 4'd4;
    else if (idx < 21) return 4'd5;
    else               return 4'd6;
  endfunction
endpackage

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int ADDR_W  = 3,
  localparam int PER_REG = REG_W / FIELD_W,
  localparam int NUM_ASG = (NUM_SRC + PER_REG - 1) / PER_REG
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [REG_W-1:0]           wdata,
  input  logic [NUM_SRC-1:0]         src_irq,
  output logic [REG_W-1:0]           rdata,
  output logic [NUM_SRC-1:0]         mask_o,
  output logic [NUM_SRC-1:0]         wen_o,
  output logic [NUM_SRC*FIELD_W-1:0] fld_o
);
  logic [NUM_SRC-1:0] mask_q, wen_q;
  logic [REG_W-1:0]   asg_word [NUM_ASG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      wen_q  <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_MASK)) mask_q <= wdata[NUM_SRC-1:0];
      if (addr == ADDR_W'(A_WAKE)) wen_q  <= wdata[NUM_SRC-1:0];
    end
  end

  for (genvar r = 0; r < NUM_ASG; r++) begin : g_asg
    for (genvar f = 0; f < PER_REG; f++) begin : g_fld
      localparam int IDX = r * PER_REG + f;
      if (IDX < NUM_SRC) begin : g_live
        logic [FIELD_W-1:0] fld_q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) fld_q <= dflt_field(IDX);
          else if (wr_en && addr == ADDR_W'(A_ASG0 + r))
            fld_q <= wdata[f*FIELD_W +: FIELD_W];
        end
        assign fld_o[IDX*FIELD_W +: FIELD_W]    = fld_q;
        assign asg_word[r][f*FIELD_W +: FIELD_W] = fld_q;
      end else begin : g_pad
        assign asg_word[r][f*FIELD_W +: FIELD_W] = '0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(A_MASK): rdata = {{(REG_W-NUM_SRC){1'b0}}, mask_q};
      ADDR_W'(A_STAT): rdata = {{(REG_W-NUM_SRC){1'b0}}, src_irq};
      ADDR_W'(A_WAKE): rdata = {{(REG_W-NUM_SRC){1'b0}}, wen_q};
      default: begin
        for (int r = 0; r < NUM_ASG; r++)
          if (addr == ADDR_W'(A_ASG0 + r)) rdata = asg_word[r];
      end
    endcase
  end

  assign mask_o = mask_q;
  assign wen_o  = wen_q;
endmodule

// File: rtl/pirq_route.sv
module pirq_route
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_irq,
  input  logic [NUM_SRC-1:0]         mask,
  input  logic [NUM_SRC*FIELD_W-1:0] fld,
  output logic [NUM_LVL-1:0]         lvl_req
);
  logic [NUM_SRC-1:0] live;
  logic [NUM_LVL-1:0] lvl_d;

  assign live = src_irq & mask;

  always_comb begin
    lvl_d = '0;
    for (int k = 0; k < NUM_LVL; k++)
      for (int i = 0; i < NUM_SRC; i++)
        if (live[i] && fld[i*FIELD_W +: FIELD_W] == FIELD_W'(k))
          lvl_d[k] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_req <= '0;
    else        lvl_req <= lvl_d;
  end
endmodule

// File: rtl/pirq_wake.sv
module pirq_wake #(
  parameter int NUM_SRC = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic [NUM_SRC-1:0] wen,
  input  logic               core_idle,
  output logic               wake
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= core_idle && |(src_irq & wen);
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 9,
  parameter int ADDR_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_irq,
  input  logic               core_idle,
  input  logic               reg_wr_en,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [NUM_LVL-1:0] lvl_req,
  output logic               wake
);
  logic [NUM_SRC-1:0]         mask, wen;
  logic [NUM_SRC*FIELD_W-1:0] fld;

  pirq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .src_irq(src_irq), .rdata(reg_rdata),
    .mask_o(mask), .wen_o(wen), .fld_o(fld)
  );

  pirq_route #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL)) u_route (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .mask(mask),
    .fld(fld), .lvl_req(lvl_req)
  );

  pirq_wake #(.NUM_SRC(NUM_SRC)) u_wake (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .wen(wen),
    .core_idle(core_idle), .wake(wake)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int NUM_SRC = 24,
  parameter int NUM_LVL = 9,
  parameter int ADDR_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_irq,
  input logic               core_idle,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [NUM_LVL-1:0] lvl_req,
  input logic               wake
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lvl_req == '0 && !wake));

  a_r4_no_source_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |=> (lvl_req == '0));

  a_r8_busy_core_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    !core_idle |=> !wake);

  a_r8_no_source_no_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (src_irq == '0) |=> !wake);

  a_r3_status_is_live: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> (reg_rdata == 32'(src_irq)));

  a_r2_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < ADDR_W'(3)) |-> (reg_rdata[31:NUM_SRC] == '0));
endmodule

bind pirq_router pirq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .core_idle(core_idle),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .lvl_req(lvl_req), .wake(wake)
);

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_irq = '0;
  logic        core_idle = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  lvl_req;
  logic        wake;

  pirq_router dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; logic [8:0] lvl; logic wk; string tag; } exp_t;
  exp_t q[$];

  logic [23:0] m_mask = '0, m_wen = '0;
  logic [3:0]  m_fld [24];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(lvl_req == e.lvl, {e.tag, " lvl_req"}, 32'(lvl_req), 32'(e.lvl));
      chk(wake == e.wk, {e.tag, " wake"}, 32'(wake), 32'(e.wk));
    end
  end

  task automatic drive(input logic [23:0] s, input logic idle, input string tag);
    exp_t e;
    @(negedge clk);
    src_irq = s;
    core_idle = idle;
    e.lvl = '0;
    for (int i = 0; i < 24; i++)
      if (s[i] && m_mask[i] && m_fld[i] < 4'd9) e.lvl[m_fld[i]] = 1'b1;
    e.wk = idle && |(s & m_wen);
    e.due = cyc + 1;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr_en = 1'b0;
    case (a)
      3'd0: m_mask = d[23:0];
      3'd2: m_wen  = d[23:0];
      3'd3, 3'd4, 3'd5:
        for (int f = 0; f < 8; f++) m_fld[(a - 3) * 8 + f] = d[f*4 +: 4];
      default: ;
    endcase
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 24; i++)
      m_fld[i] = (i < 7) ? 4'd0 : (i < 9) ? 4'd1 : (i < 13) ? 4'd2 : (i < 16) ? 4'd3 :
                 (i < 19) ? 4'd4 : (i < 21) ? 4'd5 : 4'd6;
    repeat (3) @(posedge clk);
    #1;
    chk(lvl_req == '0, "R1 reset lvl_req", 32'(lvl_req), 0);
    chk(wake == 1'b0, "R1 reset wake", 32'(wake), 0);
    rst_n = 1'b1;
    rd_chk(3'd0, 32'h0, "R1 reset mask");
    rd_chk(3'd2, 32'h0, "R1 reset wake enable");
    rd_chk(3'd3, 32'h10000000, "R1 default routing word 0");
    rd_chk(3'd4, 32'h33322221, "R1 default routing word 1");
    rd_chk(3'd5, 32'h66655444, "R1 default routing word 2");

    // R5 everything masked
    drive(24'hFFFFFF, 1'b0, "R5 all masked");
    drive(24'h000000, 1'b0, "R5 idle lines");

    // R2 reserved bits dropped on write
    wr(3'd0, 32'hFFFFFFFF);
    rd_chk(3'd0, 32'h00FFFFFF, "R2 mask reserved bits");

    // R4 each source alone on default routing
    for (int i = 0; i < 24; i++) drive(24'(1) << i, 1'b0, $sformatf("R4 source %0d", i));
    // R9 sharing and combined patterns
    drive(24'h00007F, 1'b0, "R9 level 7 shared");
    drive(24'h800180, 1'b0, "R9 mixed levels");
    drive(24'hFFFFFF, 1'b0, "R9 all sources");

    // R5 partial mask
    wr(3'd0, 32'h00F0F0F0);
    drive(24'h0F0F0F, 1'b0, "R5 masked half");
    drive(24'hFFFFFF, 1'b0, "R5 unmasked half");

    // R6 reassignment: source 0 to level 15, source 9 to level 7
    wr(3'd0, 32'h00FFFFFF);
    wr(3'd3, 32'h10000008);
    wr(3'd4, 32'h33322201);
    rd_chk(3'd3, 32'h10000008, "R6 routing readback");
    drive(24'h000001, 1'b0, "R6 source 0 moved");
    drive(24'h000200, 1'b0, "R6 source 9 moved");

    // R7 out-of-range field routes nowhere; readback of all 4 bits
    wr(3'd5, 32'hF665544C);
    rd_chk(3'd5, 32'hF665544C, "R7 field readback");
    drive(24'h010000, 1'b0, "R7 field 12 silent");
    drive(24'h800000, 1'b0, "R7 field 15 silent");
    drive(24'h810002, 1'b0, "R7 silent plus live");

    // R3 status
    drive(24'hA5A5A5, 1'b0, "R3 pattern");
    rd_chk(3'd1, 32'h00A5A5A5, "R3 status live");
    wr(3'd1, 32'h00000000);
    rd_chk(3'd1, 32'h00A5A5A5, "R3 status write ignored");
    wr(3'd0, 32'h0);
    drive(24'h5A5A5A, 1'b0, "R3 status under full mask");
    rd_chk(3'd1, 32'h005A5A5A, "R3 status ignores mask");

    // R8 wake, mask still 0
    wr(3'd2, 32'hFF000010);
    rd_chk(3'd2, 32'h00000010, "R2 wake enable reserved bits");
    drive(24'h000010, 1'b0, "R8 core busy");
    drive(24'h000010, 1'b1, "R8 idle enabled source");
    drive(24'hFFFFEF, 1'b1, "R8 idle other sources");
    drive(24'h000000, 1'b1, "R8 idle no source");
    drive(24'h000000, 1'b0, "R8 quiet");
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule